// File: doc/BRIEF.md
# Four-Lane Interleaved Double-Error-Correcting Memory Codec

This block guards a 28-bit word held in a small embedded dynamic memory. On the write side it spreads the word over four independent 15-bit codeword lanes and adds eight check bits per lane, which gives a 60-bit stored word. Each lane uses a binary cyclic code that corrects any two bit errors within its 15 bits. The write path is purely combinational: the memory captures the stored word in the same cycle as the data.

On the read side a 60-bit word arrives with a valid strobe. In the first register stage each lane computes two syndromes over GF(16). In the second stage each lane builds its error-locator polynomial, evaluates it at all fifteen positions in parallel, flips the bits it has located, and registers the de-interleaved data together with a corrected flag and an uncorrectable flag for each lane. Stored bit j belongs to lane j mod 4, so a run of up to eight adjacent flipped bits puts at most two errors in any lane. Such a run is always repaired.

Top module: `ecc_ilv_codec`

## Requirements
- R1: Data bit i goes to stored bit 32+i. Lane k holds data bits 4p+k as codeword coefficients x^(8+p), for p = 0..6. Its eight check bits are the remainder of that message polynomial times x^8, divided by x^8+x^7+x^6+x^4+1. Check bit q of lane k sits at stored bit 4q+k. This mapping is combinational from the write data.
- R2: A read of an unaltered stored word returns the original data, with all corrected and uncorrectable flags at 0.
- R3: One or two flipped bits inside a lane are corrected. The data comes back exact, and only that lane's corrected flag (bit k of the corrected output) is set.
- R4: Any run of up to 8 consecutive flipped stored bits, at any position, returns the exact data.
- R5: An error pattern whose locator degree differs from its root count sets that lane's uncorrectable flag, leaves its corrected flag at 0, and passes the lane's bits through unmodified. Three flips at stored bits 0, 4 and 16 form such a pattern in lane 0. The two flags of a lane are never both set.
- R6: Read results appear exactly 2 clock cycles after the valid input is sampled. Back-to-back reads give back-to-back results, one for each input.
- R7: While reset is asserted the read valid output, the data output and all flags are 0.
- R8: While no result is issued, the data output and the flags keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 28 | Data word to be written |
| wr_code_o | output | 60 | Interleaved stored word with check bits |
| rd_valid_i | input | 1 | Read word strobe |
| rd_code_i | input | 60 | Stored word read back from memory |
| rd_valid_o | output | 1 | Corrected result strobe |
| rd_data_o | output | 28 | Corrected, de-interleaved data |
| corr_o | output | 4 | Per-lane errors corrected flag |
| uncorr_o | output | 4 | Per-lane uncorrectable flag |

## Verification
A wrong syndrome or locator term in one lane shows up in the result issued two cycles after the affected read. It appears as a data bit of that lane flipped in the wrong position, or as a false corrected or uncorrectable flag. Because the lanes are separate, the faulty lane number can be read straight from the flag vector. A wrong interleave mapping shows up in the first burst test: the run then lands three or more errors in one lane and raises its uncorrectable flag. A wrong pipeline register shows up as a missing strobe, or as stale data in the cycle where the result is expected.

// File: rtl/ecc_ilv_pkg.sv
package ecc_ilv_pkg;
  localparam int LANES    = 4;
  localparam int LANE_K   = 7;
  localparam int LANE_N   = 15;
  localparam int PAR_W    = LANE_N - LANE_K;
  localparam int GF_M     = 4;
  localparam int GF_ORDER = (1 << GF_M) - 1;
  localparam int DATA_W   = LANES * LANE_K;
  localparam int CODE_W   = LANES * LANE_N;
  localparam int PAR_TOT  = LANES * PAR_W;
  localparam logic [PAR_W:0] GEN_POLY  = 9'h1D1;
  localparam logic [GF_M:0]  PRIM_POLY = 5'h13;

  typedef logic [GF_M-1:0] gf_t;

  function automatic gf_t gf_xtime(gf_t a);
    gf_t r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ PRIM_POLY[GF_M-1:0];
    return r;
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t p;
    gf_t x;
    p = '0;
    x = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_xtime(x);
    end
    return p;
  endfunction

  // alpha^e, e in 0..GF_ORDER-1
  function automatic gf_t alpha_pow(int e);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < GF_ORDER; i++) begin
      if (i < e) r = gf_xtime(r);
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc
  import ecc_ilv_pkg::*;
(
  input  logic [LANE_K-1:0] msg_i,
  output logic [PAR_W-1:0]  par_o
);
  logic [PAR_W-1:0] rem;
  logic             fb;

  // feedback shift register unrolled over the message bits, msb first
  always_comb begin
    rem = '0;
    fb  = 1'b0;
    for (int i = LANE_K - 1; i >= 0; i--) begin
      fb  = msg_i[i] ^ rem[PAR_W-1];
      rem = {rem[PAR_W-2:0], 1'b0};
      if (fb) rem = rem ^ GEN_POLY[PAR_W-1:0];
    end
    par_o = rem;
  end
endmodule

// File: rtl/ecc_lane_synd.sv
module ecc_lane_synd
  import ecc_ilv_pkg::*;
(
  input  logic [LANE_N-1:0] cw_i,
  output gf_t               s1_o,
  output gf_t               s3_o
);
  always_comb begin
    s1_o = '0;
    s3_o = '0;
    for (int j = 0; j < LANE_N; j++) begin
      if (cw_i[j]) begin
        s1_o = s1_o ^ alpha_pow(j);
        s3_o = s3_o ^ alpha_pow((3 * j) % GF_ORDER);
      end
    end
  end
endmodule

// File: rtl/ecc_lane_locate.sv
module ecc_lane_locate
  import ecc_ilv_pkg::*;
(
  input  gf_t               s1_i,
  input  gf_t               s3_i,
  input  logic [LANE_N-1:0] cw_i,
  output logic [LANE_N-1:0] cw_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  gf_t              s1_sq;
  gf_t              e_term;
  logic [1:0]       deg;
  logic [LANE_N-1:0] hit;
  logic [3:0]       roots;
  gf_t              val;

  // locator scaled by S1: S1 + S1^2 x + (S3 + S1^3) x^2, division-free
  assign s1_sq  = gf_mul(s1_i, s1_i);
  assign e_term = s3_i ^ gf_mul(s1_sq, s1_i);

  always_comb begin
    if (e_term != '0)    deg = 2'd2;
    else if (s1_i != '0) deg = 2'd1;
    else                 deg = 2'd0;
  end

  // parallel search over all positions, x = alpha^-j
  always_comb begin
    hit   = '0;
    roots = '0;
    val   = '0;
    for (int j = 0; j < LANE_N; j++) begin
      val = s1_i
          ^ gf_mul(s1_sq,  alpha_pow((GF_ORDER - j) % GF_ORDER))
          ^ gf_mul(e_term, alpha_pow((2 * GF_ORDER - 2 * j) % GF_ORDER));
      hit[j] = (deg != 2'd0) && (val == '0);
      roots  = roots + {3'd0, hit[j]};
    end
  end

  assign uncorr_o = (deg != 2'd0) && (roots != {2'd0, deg});
  assign corr_o   = (deg != 2'd0) && !uncorr_o;
  assign cw_o     = uncorr_o ? cw_i : (cw_i ^ hit);
endmodule

// File: rtl/ecc_ilv_codec.sv
module ecc_ilv_codec
  import ecc_ilv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] wr_code_o,
  input  logic              rd_valid_i,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LANES-1:0]  corr_o,
  output logic [LANES-1:0]  uncorr_o
);
  logic [LANES-1:0][LANE_K-1:0] wmsg;
  logic [LANES-1:0][PAR_W-1:0]  wpar;
  logic [LANES-1:0][LANE_N-1:0] rcw_d, rcw_q, fix_d;
  logic [LANES-1:0][GF_M-1:0]   s1_d, s3_d, s1_q, s3_q;
  logic [LANES-1:0]             corr_d, uncorr_d;
  logic                         v1_q;
  logic [DATA_W-1:0]            data_d;

  assign wr_code_o[CODE_W-1:PAR_TOT] = wr_data_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar p = 0; p < LANE_K; p++) begin : g_msg
      assign wmsg[k][p] = wr_data_i[LANES*p+k];
    end
    for (genvar q = 0; q < PAR_W; q++) begin : g_par
      assign wr_code_o[LANES*q+k] = wpar[k][q];
    end
    for (genvar j = 0; j < LANE_N; j++) begin : g_rcw
      assign rcw_d[k][j] = rd_code_i[LANES*j+k];
    end

    ecc_lane_enc u_enc (
      .msg_i (wmsg[k]),
      .par_o (wpar[k])
    );

    ecc_lane_synd u_synd (
      .cw_i (rcw_d[k]),
      .s1_o (s1_d[k]),
      .s3_o (s3_d[k])
    );

    ecc_lane_locate u_loc (
      .s1_i     (s1_q[k]),
      .s3_i     (s3_q[k]),
      .cw_i     (rcw_q[k]),
      .cw_o     (fix_d[k]),
      .corr_o   (corr_d[k]),
      .uncorr_o (uncorr_d[k])
    );
  end

  always_comb begin
    data_d = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int p = 0; p < LANE_K; p++) begin
        data_d[LANES*p+k] = fix_d[k][PAR_W+p];
      end
    end
  end

  // stage 1: syndromes and received word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      rcw_q <= '0;
      s1_q  <= '0;
      s3_q  <= '0;
    end else begin
      v1_q <= rd_valid_i;
      if (rd_valid_i) begin
        rcw_q <= rcw_d;
        s1_q  <= s1_d;
        s3_q  <= s3_d;
      end
    end
  end

  // stage 2: corrected data and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      corr_o     <= '0;
      uncorr_o   <= '0;
    end else begin
      rd_valid_o <= v1_q;
      if (v1_q) begin
        rd_data_o <= data_d;
        corr_o    <= corr_d;
        uncorr_o  <= uncorr_d;
      end
    end
  end
endmodule

// File: rtl/ecc_ilv_codec_chk.sv
module ecc_ilv_codec_chk
  import ecc_ilv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CODE_W-1:0] wr_code_o,
  input logic              rd_valid_i,
  input logic [CODE_W-1:0] rd_code_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [LANES-1:0]  corr_o,
  input logic [LANES-1:0]  uncorr_o
);
  assert_loopback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_code_i == wr_code_o) |-> ##2
      (rd_data_o == $past(wr_data_i, 2) && corr_o == '0 && uncorr_o == '0));

  assert_flag_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o & uncorr_o) == '0);

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> ##2 rd_valid_o);

  assert_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |-> ##2 !rd_valid_o);

  assert_reset_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (!rd_valid_o && rd_data_o == '0 && corr_o == '0 && uncorr_o == '0));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> ($stable(rd_data_o) && $stable(corr_o) && $stable(uncorr_o)));
endmodule

bind ecc_ilv_codec ecc_ilv_codec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_data_i  (wr_data_i),
  .wr_code_o  (wr_code_o),
  .rd_valid_i (rd_valid_i),
  .rd_code_i  (rd_code_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .corr_o     (corr_o),
  .uncorr_o   (uncorr_o)
);

// File: tb/sim_ecc_ilv_codec.sv
`timescale 1ns/1ps
module sim_ecc_ilv_codec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] wr_data_i = '0;
  logic [59:0] wr_code_o;
  logic        rd_valid_i = 1'b0;
  logic [59:0] rd_code_i = '0;
  logic        rd_valid_o;
  logic [27:0] rd_data_o;
  logic [3:0]  corr_o, uncorr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  ecc_ilv_codec u0 (.*);

  localparam int NV = 10;
  localparam logic [27:0] V_DATA [NV] = '{
    28'h0000000, 28'hFFFFFFF, 28'h5A5A5A5, 28'h1234567, 28'hABCDEF1,
    28'h7654321, 28'h0F0F0F0, 28'h3C3C3C3, 28'h2468ACE, 28'h9E3779B};
  localparam logic [59:0] V_MASK [NV] = '{
    60'h0, 60'h0, 60'h1 << 32, (60'h1 << 0) | (60'h1 << 40), 60'hFF << 20,
    60'hFF << 28, (60'h1 << 12) | (60'h1 << 1) | (60'h1 << 6) | (60'h1 << 59),
    (60'h1 << 0) | (60'h1 << 4) | (60'h1 << 16), 60'hF << 56, 60'h1F << 55};
  localparam logic [3:0] V_CORR [NV] = '{
    4'h0, 4'h0, 4'h1, 4'h1, 4'hF, 4'hF, 4'hF, 4'h0, 4'hF, 4'hF};
  localparam logic [3:0] V_UNC [NV] = '{
    4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0};

  function automatic logic [7:0] ref_par(input logic [6:0] m);
    logic [14:0] r;
    r = {m, 8'h00};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'h1D1 << (i - 8));
    return r[7:0];
  endfunction

  function automatic logic [59:0] ref_code(input logic [27:0] d);
    logic [59:0] c;
    logic [6:0]  m;
    logic [7:0]  p;
    c = '0;
    c[59:32] = d;
    for (int k = 0; k < 4; k++) begin
      for (int q = 0; q < 7; q++) m[q] = d[4*q+k];
      p = ref_par(m);
      for (int q = 0; q < 8; q++) c[4*q+k] = p[q];
    end
    return c;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // single read: drive, check no early result, check result at +2
  task automatic do_read(input logic [27:0] d, input logic [59:0] mask,
                         input logic [3:0] ec, input logic [3:0] eu,
                         input logic [27:0] ed);
    @(negedge clk_i);
    wr_data_i  = d;
    #1;
    check(wr_code_o == ref_code(d), "R1 stored word", 64'(wr_code_o), 64'(ref_code(d)));
    rd_code_i  = ref_code(d) ^ mask;
    rd_valid_i = 1'b1;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    check(rd_valid_o == 1'b0, "R6 no early valid", 64'(rd_valid_o), 64'd0);
    @(negedge clk_i);
    check(rd_valid_o == 1'b1, "R6 valid at 2", 64'(rd_valid_o), 64'd1);
    check(rd_data_o == ed, "R2/R3/R4/R5 data", 64'(rd_data_o), 64'(ed));
    check(corr_o == ec, "R3/R4 corrected flags", 64'(corr_o), 64'(ec));
    check(uncorr_o == eu, "R5 uncorrectable flags", 64'(uncorr_o), 64'(eu));
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R7 reset state
    check(rd_valid_o == 1'b0, "R7 valid in reset", 64'(rd_valid_o), 64'd0);
    check(rd_data_o == '0, "R7 data in reset", 64'(rd_data_o), 64'd0);
    check({corr_o, uncorr_o} == '0, "R7 flags in reset", 64'({corr_o, uncorr_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++)
      do_read(V_DATA[v], V_MASK[v], V_CORR[v], V_UNC[v], V_DATA[v]);

    // R5: uncorrectable triple on data bits of lane 1 passes bits through
    do_read(28'h1111111, (60'h1 << 33) | (60'h1 << 37) | (60'h1 << 49), 4'h0, 4'h2,
            28'h1111111 ^ 28'h0020022);

    // R4: every 8-bit burst position on one word
    for (int s = 0; s <= 52; s += 4)
      do_read(28'hC0FFEE5 ^ 28'(s), 60'hFF << s, 4'hF, 4'h0, 28'hC0FFEE5 ^ 28'(s));

    // R8: hold while idle, with a changing read bus
    @(negedge clk_i);
    rd_code_i = ~rd_code_i;
    repeat (3) @(negedge clk_i);
    check(rd_valid_o == 1'b0, "R8 idle valid", 64'(rd_valid_o), 64'd0);
    check(rd_data_o == (28'hC0FFEE5 ^ 28'd52), "R8 data held", 64'(rd_data_o),
          64'(28'hC0FFEE5 ^ 28'd52));
    check(corr_o == 4'hF, "R8 flags held", 64'(corr_o), 64'hF);

    // R6: back-to-back reads
    @(negedge clk_i);
    wr_data_i  = 28'h0A0B0C0;
    rd_code_i  = ref_code(28'h0A0B0C0);
    rd_valid_i = 1'b1;
    @(negedge clk_i);
    wr_data_i  = 28'h50607D8;
    rd_code_i  = ref_code(28'h50607D8) ^ (60'h1 << 35);
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    check(rd_valid_o && rd_data_o == 28'h0A0B0C0 && corr_o == 4'h0,
          "R6 first of pair", 64'(rd_data_o), 64'(28'h0A0B0C0));
    @(negedge clk_i);
    check(rd_valid_o && rd_data_o == 28'h50607D8 && corr_o == 4'h8,
          "R6 second of pair", 64'({corr_o, rd_data_o}), 64'({4'h8, 28'h50607D8}));
    @(negedge clk_i);
    check(rd_valid_o == 1'b0, "R6 single result each", 64'(rd_valid_o), 64'd0);

    done = 1;
    summary();
  end
endmodule